// File: doc/BRIEF.md
# Request-Driven Clock Output Gating

This block drives the enable pattern of a bank of differential clock outputs. Each output lane has a true phase and a complement phase, produced from a free-running reference clock. Every reference cycle, a running lane alternates between a true-high phase and a complement-high phase, so each output clock period is two reference cycles long. Nine active-low request inputs decide, lane by lane, whether a lane may keep running.

Each lane has two configuration bits of state. A stop-enable bit says whether the lane may be stopped at all. A 4-bit select field says which of the nine requests governs it. When the governing request is released (driven high), a stoppable lane first completes the phase it is in. It then parks with both phases low. When the request is taken again (driven low), the lane restarts with a full true-high phase. Lanes that are not stoppable, or whose select names no request, run without pause.

Each lane is a three-state machine:
- `LANE_HI`: true high, complement low.
- `LANE_LO`: true low, complement high.
- `LANE_PARK`: both low.

The transitions are:
- hi_to_lo: always taken from `LANE_HI`.
- lo_to_hi: from `LANE_LO` when no stop is requested.
- lo_to_park: from `LANE_LO` when a stop is requested.
- park_hold: stay in `LANE_PARK` while the stop is still requested.
- park_to_hi: leave `LANE_PARK` once the stop request clears.

Reset places every lane in `LANE_PARK`.

Top module: `clkreq_gate`

## Requirements
- R1: Request k (k = 1..9) is bit k-1 of `req_n`; it is active low. Each request passes through two flip-flops before it is used. A change on a request pin therefore moves no lane before the third rising reference edge after that change.
- R2: A lane whose `stop_en` bit is 0 toggles every reference cycle whatever the request pins do. A true-high cycle on such a lane is always followed by a complement-high cycle.
- R3: The select field of lane i is `req_sel[4i+3:4i]`. Values 1 to 9 pick the request with that number. Values 0 and 10 to 15 pick none, and a lane with such a select never stops. Releasing a request stops only the stoppable lanes that select it.
- R4: After its selected request is released, a stoppable lane never parks from the true-high phase. It passes through one complement-high cycle (true 0, complement 1) and then parks. Parking happens on the 3rd or 4th rising edge after the request pin rises.
- R5: A parked lane holds true 0 and complement 0 for as long as its selected request stays released.
- R6: When the selected request is taken again (pin low), the lane leaves the parked state on the 3rd rising edge after the pin falls. Its first running phase is true 1, complement 0.
- R7: While a lane runs, every high pulse on either phase lasts exactly one reference cycle. No runt pulse appears on stop or restart. True and complement are never high together.
- R8: While `rst_n` is low, all outputs are 0. The synchronizers reset to "released", so stoppable lanes stay parked until a taken request has crossed both flops. A non-stoppable lane shows true 1, complement 0 after the first rising edge following reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low reset |
| req_n | input | NUM_REQ (9) | Active-low clock requests; bit k-1 is request k |
| stop_en | input | NUM_OUT | Per-lane stop enable; 1 lets the lane be stopped |
| req_sel | input | NUM_OUT*SEL_W | Per-lane request select, 4 bits per lane |
| true_en | output | NUM_OUT | True-phase enable of each lane |
| comp_en | output | NUM_OUT | Complement-phase enable of each lane |

## Verification
The outputs decode the lane state directly, so a wrong state shows at the ports in the same cycle it is entered. A park from the true-high phase shows as a true pulse cut short or a missing complement pulse. A wrong restart state shows as a complement-first pulse. A wrong select decode or a missing synchronizer stage shows as a park that comes at the wrong edge, on the wrong lane, or not at all. These faults appear within four reference cycles of the request edge. The bench sweeps every pairing of the select value and the released request.

// File: rtl/clkreq_gate_pkg.sv
package clkreq_gate_pkg;
    typedef enum logic [1:0] {
        LANE_PARK = 2'd0,
        LANE_HI   = 2'd1,
        LANE_LO   = 2'd2
    } lane_state_e;
endpackage

// File: rtl/req_sync.sv
module req_sync #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] req_n_async,
    output logic [WIDTH-1:0] req_released
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // two flops per request; reset value means "released"
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1_q[b] <= 1'b1;
                stage2_q[b] <= 1'b1;
            end else begin
                stage1_q[b] <= req_n_async[b];
                stage2_q[b] <= stage1_q[b];
            end
        end
    end

    assign req_released = stage2_q;
endmodule

// File: rtl/req_route.sv
module req_route #(
    parameter int NUM_REQ = 9,
    parameter int SEL_W   = 4
) (
    input  logic [NUM_REQ-1:0] req_released,
    input  logic [SEL_W-1:0]   sel,
    input  logic               stop_en,
    output logic               stop_req
);
    // select value k+1 picks request bit k; other codes pick nothing
    always_comb begin
        stop_req = 1'b0;
        for (int k = 0; k < NUM_REQ; k++) begin
            if (int'(sel) == k + 1) begin
                stop_req = stop_en & req_released[k];
            end
        end
    end
endmodule

// File: rtl/lane_fsm.sv
module lane_fsm
    import clkreq_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    output logic true_en,
    output logic comp_en
);
    lane_state_e state_q;
    lane_state_e state_nx;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            LANE_HI:   state_nx = LANE_LO;                          // hi_to_lo
            LANE_LO:   state_nx = stop_req ? LANE_PARK : LANE_HI;   // lo_to_park / lo_to_hi
            LANE_PARK: state_nx = stop_req ? LANE_PARK : LANE_HI;   // park_hold / park_to_hi
            default:   state_nx = LANE_PARK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LANE_PARK;
        else        state_q <= state_nx;
    end

    always_comb begin
        true_en = 1'b0;
        comp_en = 1'b0;
        unique case (state_q)
            LANE_HI:   true_en = 1'b1;
            LANE_LO:   comp_en = 1'b1;
            LANE_PARK: ;
            default:   ;
        endcase
    end

    // R7: a true-high phase lasts one cycle
    p_hi_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == LANE_HI |=> state_q == LANE_LO);

    // R7: an unstopped low phase is followed by a high phase
    p_low_resumes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LANE_LO && !stop_req) |=> state_q == LANE_HI);

    // R4: parking is only entered from the complement-high phase
    p_park_from_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LANE_PARK && $past(state_q) != LANE_PARK) |-> $past(state_q) == LANE_LO);

    // R6: restart begins with the true-high phase
    p_restart_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != LANE_PARK && $past(state_q) == LANE_PARK) |-> state_q == LANE_HI);

    // R5: a parked lane stays parked while its stop request holds
    p_park_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LANE_PARK && stop_req) |=> state_q == LANE_PARK);
endmodule

// File: rtl/clkreq_gate.sv
module clkreq_gate #(
    parameter int NUM_OUT = 8,
    parameter int NUM_REQ = 9,
    parameter int SEL_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_REQ-1:0]       req_n,
    input  logic [NUM_OUT-1:0]       stop_en,
    input  logic [NUM_OUT*SEL_W-1:0] req_sel,
    output logic [NUM_OUT-1:0]       true_en,
    output logic [NUM_OUT-1:0]       comp_en
);
    localparam int SEL_BITS = NUM_OUT * SEL_W;

    logic [NUM_REQ-1:0] req_released;
    logic [NUM_OUT-1:0] lane_stop;

    req_sync #(.WIDTH(NUM_REQ)) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_n_async  (req_n),
        .req_released (req_released)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
        localparam int SEL_LSB = i * SEL_W;

        req_route #(.NUM_REQ(NUM_REQ), .SEL_W(SEL_W)) u_route (
            .req_released (req_released),
            .sel          (req_sel[SEL_LSB +: SEL_W]),
            .stop_en      (stop_en[i]),
            .stop_req     (lane_stop[i])
        );

        lane_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .stop_req (lane_stop[i]),
            .true_en  (true_en[i]),
            .comp_en  (comp_en[i])
        );

        // R2: a non-stoppable lane follows each true pulse with a complement pulse
        p_free_lane_toggles_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!stop_en[i] && $past(!stop_en[i]) && $past(true_en[i])) |-> comp_en[i]);

        // R7: the two phases never overlap at the ports
        p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !(true_en[i] && comp_en[i]));
    end

    if (SEL_BITS != $bits(req_sel)) begin : g_bad_width
        $error("select bus width mismatch");
    end
endmodule

// File: tb/tb_clkreq_gate.sv
`timescale 1ns/1ps
module tb_clkreq_gate;
    localparam int NO = 4;
    localparam int NR = 9;
    localparam int SW = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic              rst_n;
    logic [NR-1:0]     req_n;
    logic [NO-1:0]     stop_en;
    logic [SW-1:0]     sel_q [NO];
    logic [NO*SW-1:0]  req_sel;
    logic [NO-1:0]     true_en;
    logic [NO-1:0]     comp_en;

    always_comb begin
        for (int i = 0; i < NO; i++) req_sel[i*SW +: SW] = sel_q[i];
    end

    clkreq_gate #(.NUM_OUT(NO), .NUM_REQ(NR), .SEL_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .stop_en(stop_en),
        .req_sel(req_sel), .true_en(true_en), .comp_en(comp_en)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // pulse-shape monitor for every lane (R4, R6, R7)
    bit mon_en = 1'b0;
    bit prev_t [NO];
    bit prev_c [NO];
    int run_t  [NO];
    int run_c  [NO];

    always @(negedge clk) begin
        if (mon_en) begin
            for (int i = 0; i < NO; i++) begin
                bit pk, ppk;
                pk  = !true_en[i] && !comp_en[i];
                ppk = !prev_t[i] && !prev_c[i];
                if (true_en[i] && comp_en[i])
                    chk(1'b0, "R7", "both phases high", 1, 0);
                if (true_en[i]) run_t[i]++;
                else if (run_t[i] > 0) begin
                    chk(run_t[i] == 1, "R7", "true pulse width", run_t[i], 1);
                    run_t[i] = 0;
                end
                if (comp_en[i]) run_c[i]++;
                else if (run_c[i] > 0) begin
                    chk(run_c[i] == 1, "R7", "comp pulse width", run_c[i], 1);
                    run_c[i] = 0;
                end
                if (pk && !ppk)
                    chk(!prev_t[i] && prev_c[i], "R4", "phase before park (t*2+c)",
                        int'(prev_t[i]) * 2 + int'(prev_c[i]), 1);
                if (!pk && ppk)
                    chk(true_en[i] && !comp_en[i], "R6", "first phase after park (t*2+c)",
                        int'(true_en[i]) * 2 + int'(comp_en[i]), 2);
                prev_t[i] = true_en[i];
                prev_c[i] = comp_en[i];
            end
        end
    end

    function automatic bit parked(input int i);
        return !true_en[i] && !comp_en[i];
    endfunction

    // lane0 selects request k; request j is released and retaken
    task automatic run_case(input int k, input int j);
        int  first_park;
        int  first_run;
        bit  free_bad;
        bit  lane3_parked;
        sel_q[0] = SW'(k);
        repeat (4) @(negedge clk);
        req_n[j-1] = 1'b1;
        first_park = 0;
        free_bad = 1'b0;
        for (int n = 1; n <= 8; n++) begin
            @(negedge clk);
            if (parked(0) && first_park == 0) first_park = n;
            if (first_park != 0 && !parked(0))
                chk(1'b0, "R5", "lane0 left park while released", n, 0);
            if (parked(1) || parked(2)) free_bad = 1'b1;
        end
        lane3_parked = parked(3);
        if (j == k)
            chk(first_park == 3 || first_park == 4, "R4", "edges to park", first_park, 3);
        else
            chk(first_park == 0, "R3", "unselected request stopped lane0", first_park, 0);
        chk(lane3_parked == (j == 9), "R3", "lane3 (select 9) parked",
            int'(lane3_parked), int'(j == 9));
        req_n[j-1] = 1'b0;
        first_run = 0;
        for (int n = 1; n <= 6; n++) begin
            @(negedge clk);
            if (true_en[0] && first_run == 0) first_run = n;
            if (parked(1) || parked(2)) free_bad = 1'b1;
        end
        if (j == k)
            chk(first_run == 3, "R6", "edges to restart", first_run, 3);
        chk(!free_bad, "R2", "free lane parked", int'(free_bad), 0);
    endtask

    initial begin
        rst_n   = 1'b0;
        req_n   = '0;
        stop_en = 4'b1101;      // lane1 not stoppable
        sel_q[0] = 4'd1;
        sel_q[1] = 4'd1;
        sel_q[2] = 4'd0;        // selects nothing
        sel_q[3] = 4'd9;
        for (int i = 0; i < NO; i++) begin
            prev_t[i] = 1'b0; prev_c[i] = 1'b0; run_t[i] = 0; run_c[i] = 0;
        end
        repeat (3) @(negedge clk);
        chk(true_en == '0 && comp_en == '0, "R8", "outputs in reset",
            int'({true_en, comp_en}), 0);
        rst_n  = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);
        chk(true_en[1] && !comp_en[1], "R8", "free lane first phase (t*2+c)",
            int'(true_en[1]) * 2 + int'(comp_en[1]), 2);
        chk(parked(0), "R8", "stoppable lane parked after reset", int'(parked(0)), 1);
        chk(parked(3), "R1", "lane3 parked before sync completes", int'(parked(3)), 1);
        repeat (6) @(negedge clk);
        chk(!parked(0), "R1", "lane0 running after sync", int'(parked(0)), 0);

        for (int k = 1; k <= 9; k++)
            for (int j = 1; j <= 9; j++)
                run_case(k, j);

        // out-of-range select never stops
        sel_q[0] = 4'd12;
        repeat (2) @(negedge clk);
        req_n = '1;
        begin
            bit any_park;
            any_park = 1'b0;
            for (int n = 0; n < 8; n++) begin
                @(negedge clk);
                if (parked(0) || parked(1) || parked(2)) any_park = 1'b1;
            end
            chk(!any_park, "R3", "select 12/0 or free lane parked", int'(any_park), 0);
            chk(parked(3), "R5", "lane3 held parked", int'(parked(3)), 1);
        end
        req_n = '0;
        repeat (6) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule